// File: doc/BRIEF.md
# Machine-Cycle and Reset Sequencer

This block derives the machine-cycle timing of an 8-bit core from its oscillator clock. A free-running phase counter splits every run of 12 oscillator clocks into one machine cycle. The block marks the last clock of each machine cycle with an enable pulse and places two code-fetch strobes at fixed phases inside it. It follows each instruction's length, using a cycle class that the decoder reports during the first machine cycle, and signals the final clock of every instruction. In the second machine cycle of an external data move, both fetch strobes are withheld.

The block also qualifies the board's active-high reset pin. The pin passes through a two-stage synchronizer and must then stay high for two full machine cycles before the core's internal reset is raised. Shorter glitches are discarded. The internal reset is dropped only on a machine-cycle boundary, so the first instruction always starts at phase 0. The architectural reset values for the program counter, accumulator, B, status word, data pointer and stack pointer are presented as constant outputs for the core's register file to load while the internal reset is high.

Top module: `mcycle_sequencer`

## Requirements
- R1: `mc_en` is high for exactly one clock in every 12, at phase 11. The phase counts 0..11 and is 0 on the first clock after `arst_n` is released.
- R2: Outside reset, `fetch_a` is high only at phase 1 and `fetch_b` only at phase 7 of each machine cycle. Both are high in every machine cycle except the one named in R10.
- R3: When `rst_pin` is held high for at least 24 consecutive clocks (two machine cycles), `core_rst` rises. With the default two synchronizer stages, this happens on the 26th rising edge after the pin goes high.
- R4: A `rst_pin` pulse of 23 clocks or fewer has no effect. `core_rst` stays low, and the fetch strobes and `insn_done` continue unchanged.
- R5: `core_rst` falls on the first machine-cycle boundary (the edge that ends phase 11) at which the synchronized pin is low. This is at least 3 clocks after the pin falls. The following clock is phase 0 of the first cycle of a new instruction.
- R6: While `core_rst` is high, `fetch_a`, `fetch_b` and `insn_done` stay low and `mc_en` keeps its period.
- R7: The reset value outputs are constant: `rv_pc`, `rv_acc`, `rv_b`, `rv_psw` and `rv_dptr` are 0, and `rv_sp` is 07h.
- R8: `insn_class` is sampled on the last clock of the first machine cycle of each instruction. Its encoding is: 00 = one cycle, 01 = two cycles, 10 = external data move (two cycles), 11 = four cycles (multiply/divide).
- R9: `insn_done` is high for one clock, at phase 11 of the final machine cycle of each instruction. The next clock begins the next instruction.
- R10: For class 10, both fetch strobes occur in the first machine cycle and neither occurs in the second.
- R11: Asserting `arst_n` low immediately raises `core_rst` and clears the phase. After release with `rst_pin` low, `core_rst` falls at the 12th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous active-low power-on reset of the sequencer itself |
| rst_pin | input | 1 | Active-high board reset pin, asynchronous to nothing in particular |
| insn_class | input | 2 | Cycle class of the current instruction from the decoder (R8 encoding) |
| mc_en | output | 1 | Machine-cycle enable, last clock of each machine cycle |
| fetch_a | output | 1 | First code-fetch strobe |
| fetch_b | output | 1 | Second code-fetch strobe |
| insn_done | output | 1 | Last clock of the last machine cycle of an instruction |
| core_rst | output | 1 | Qualified internal reset for the core |
| rv_pc | output | 16 | Program counter reset value |
| rv_acc | output | 8 | Accumulator reset value |
| rv_b | output | 8 | B register reset value |
| rv_psw | output | 8 | Status word reset value |
| rv_sp | output | 8 | Stack pointer reset value |
| rv_dptr | output | 16 | Data pointer reset value |

## Verification
The bench probes the qualification threshold from both sides. A 23-clock pulse must leave the core running. A design that counted machine-cycle samples, or counted one edge too few, would reset the core there instead. Pulses of 24, 25, 31 and 40 clocks must each raise `core_rst` on exactly the 26th edge and release it on the first boundary after the synchronizer clears. Releasing mid-cycle would start the first instruction at a non-zero phase, and the fetch checks would then catch it. Every ordered pair of the four classes is swept, so a cycle count that is off by one, a class sampled in the wrong cycle, or fetch suppression placed in the wrong cycle or class shows up as a misplaced `insn_done` or strobe. A reset asserted in the middle of a four-cycle instruction confirms that the cycle count restarts.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  // Instruction cycle classes reported by the decoder.
  typedef enum logic [1:0] {
    CLS_ONE  = 2'b00,
    CLS_TWO  = 2'b01,
    CLS_XDM  = 2'b10,
    CLS_FOUR = 2'b11
  } insn_cls_e;

  // Longest instruction, in machine cycles, and width of its index.
  localparam int unsigned MAX_MCYC = 4;
  localparam int unsigned CIW      = $clog2(MAX_MCYC);

  // Architectural reset values presented to the core.
  localparam logic [15:0] RV_PC   = 16'h0000;
  localparam logic [7:0]  RV_ACC  = 8'h00;
  localparam logic [7:0]  RV_B    = 8'h00;
  localparam logic [7:0]  RV_PSW  = 8'h00;
  localparam logic [7:0]  RV_SP   = 8'h07;
  localparam logic [15:0] RV_DPTR = 16'h0000;

  // Index of the final machine cycle of an instruction of class c.
  function automatic logic [CIW-1:0] cls_last_idx(input insn_cls_e c);
    unique case (c)
      CLS_ONE:  cls_last_idx = CIW'(0);
      CLS_TWO:  cls_last_idx = CIW'(1);
      CLS_XDM:  cls_last_idx = CIW'(1);
      default:  cls_last_idx = CIW'(MAX_MCYC - 1);
    endcase
  endfunction

endpackage

// File: rtl/mcs_phase.sv
module mcs_phase #(
  parameter int unsigned DIV = 12,
  localparam int unsigned PW = $clog2(DIV)
) (
  input  logic          clk,
  input  logic          arst_n,
  output logic [PW-1:0] phase,
  output logic          mc_end
);

  logic [PW-1:0] phase_d;

  assign mc_end = (phase == PW'(DIV - 1));

  always_comb begin
    if (mc_end) phase_d = '0;
    else        phase_d = phase + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) phase <= '0;
    else         phase <= phase_d;
  end

endmodule

// File: rtl/mcs_rst_qual.sv
module mcs_rst_qual #(
  parameter int unsigned DIV         = 12,
  parameter int unsigned RST_MCYC    = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LIMIT      = DIV * RST_MCYC,
  localparam int unsigned CW         = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_pin,
  input  logic mc_end,
  output logic core_rst
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   pin_s;
  logic [CW-1:0]          hi_cnt, hi_cnt_d;
  logic                   core_rst_d;
  logic                   qualify;

  // Synchronizer chain, shaped by the stage count.
  if (SYNC_STAGES == 1) begin : g_sync_one
    assign sync_d = rst_pin;
  end else begin : g_sync_chain
    assign sync_d = {sync_q[SYNC_STAGES-2:0], rst_pin};
  end

  assign pin_s = sync_q[SYNC_STAGES-1];

  // Run length of the synchronized pin, saturating at the threshold.
  assign qualify = pin_s && (hi_cnt == CW'(LIMIT - 1));

  always_comb begin
    if (!pin_s)       hi_cnt_d = '0;
    else if (qualify) hi_cnt_d = hi_cnt;
    else              hi_cnt_d = hi_cnt + 1'b1;
  end

  // Set after a qualified run; clear only on a machine-cycle boundary.
  always_comb begin
    core_rst_d = core_rst;
    if (qualify)                          core_rst_d = 1'b1;
    else if (core_rst && !pin_s && mc_end) core_rst_d = 1'b0;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q   <= '0;
      hi_cnt   <= '0;
      core_rst <= 1'b1;
    end else begin
      sync_q   <= sync_d;
      hi_cnt   <= hi_cnt_d;
      core_rst <= core_rst_d;
    end
  end

endmodule

// File: rtl/mcs_insn_seq.sv
module mcs_insn_seq
  import mcs_pkg::*;
#(
  parameter int unsigned PW = 4,
  parameter int unsigned FA = 1,
  parameter int unsigned FB = 7
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic [PW-1:0] phase,
  input  logic          mc_end,
  input  logic          core_rst,
  input  logic [1:0]    insn_class,
  output logic          fetch_a,
  output logic          fetch_b,
  output logic          insn_done
);

  logic [CIW-1:0] cyc_idx, cyc_idx_d;
  insn_cls_e      cls_q, cls_d;
  insn_cls_e      eff_cls;
  logic           at_last;
  logic           suppress;
  logic           first_cyc;

  assign first_cyc = (cyc_idx == '0);

  // The decoder's class is live during the first cycle, held afterwards.
  assign eff_cls  = first_cyc ? insn_cls_e'(insn_class) : cls_q;
  assign at_last  = (cyc_idx == cls_last_idx(eff_cls));
  assign suppress = (cls_q == CLS_XDM) && (cyc_idx == CIW'(1));

  assign fetch_a   = !core_rst && !suppress && (phase == PW'(FA));
  assign fetch_b   = !core_rst && !suppress && (phase == PW'(FB));
  assign insn_done = !core_rst && mc_end && at_last;

  always_comb begin
    cyc_idx_d = cyc_idx;
    cls_d     = cls_q;
    if (core_rst) begin
      cyc_idx_d = '0;
      cls_d     = CLS_ONE;
    end else if (mc_end) begin
      if (first_cyc) cls_d = insn_cls_e'(insn_class);
      if (at_last)   cyc_idx_d = '0;
      else           cyc_idx_d = cyc_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cyc_idx <= '0;
      cls_q   <= CLS_ONE;
    end else begin
      cyc_idx <= cyc_idx_d;
      cls_q   <= cls_d;
    end
  end

endmodule

// File: rtl/mcycle_sequencer.sv
module mcycle_sequencer
  import mcs_pkg::*;
#(
  parameter int unsigned DIV         = 12,
  parameter int unsigned FA          = 1,
  parameter int unsigned FB          = 7,
  parameter int unsigned RST_MCYC    = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PW         = $clog2(DIV)
) (
  input  logic        clk,
  input  logic        arst_n,
  input  logic        rst_pin,
  input  logic [1:0]  insn_class,
  output logic        mc_en,
  output logic        fetch_a,
  output logic        fetch_b,
  output logic        insn_done,
  output logic        core_rst,
  output logic [15:0] rv_pc,
  output logic [7:0]  rv_acc,
  output logic [7:0]  rv_b,
  output logic [7:0]  rv_psw,
  output logic [7:0]  rv_sp,
  output logic [15:0] rv_dptr
);

  logic [PW-1:0] phase;
  logic          mc_end;

  mcs_phase #(.DIV(DIV)) u_phase (
    .clk    (clk),
    .arst_n (arst_n),
    .phase  (phase),
    .mc_end (mc_end)
  );

  mcs_rst_qual #(
    .DIV         (DIV),
    .RST_MCYC    (RST_MCYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_rst_qual (
    .clk      (clk),
    .arst_n   (arst_n),
    .rst_pin  (rst_pin),
    .mc_end   (mc_end),
    .core_rst (core_rst)
  );

  mcs_insn_seq #(.PW(PW), .FA(FA), .FB(FB)) u_insn_seq (
    .clk        (clk),
    .arst_n     (arst_n),
    .phase      (phase),
    .mc_end     (mc_end),
    .core_rst   (core_rst),
    .insn_class (insn_class),
    .fetch_a    (fetch_a),
    .fetch_b    (fetch_b),
    .insn_done  (insn_done)
  );

  assign mc_en   = mc_end;
  assign rv_pc   = RV_PC;
  assign rv_acc  = RV_ACC;
  assign rv_b    = RV_B;
  assign rv_psw  = RV_PSW;
  assign rv_sp   = RV_SP;
  assign rv_dptr = RV_DPTR;

endmodule

// File: rtl/mcs_checker.sv
module mcs_checker #(
  parameter int unsigned DIV      = 12,
  parameter int unsigned FA       = 1,
  parameter int unsigned FB       = 7,
  parameter int unsigned RST_MCYC = 2,
  localparam int unsigned PW      = $clog2(DIV),
  localparam int unsigned LIMIT   = DIV * RST_MCYC,
  localparam int unsigned CW      = $clog2(LIMIT + 1)
) (
  input logic clk,
  input logic arst_n,
  input logic rst_pin,
  input logic mc_en,
  input logic fetch_a,
  input logic fetch_b,
  input logic insn_done,
  input logic core_rst
);

  logic [PW-1:0] since_en;
  logic [CW-1:0] run_cnt;
  logic          long_seen;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      since_en  <= '0;
      run_cnt   <= '0;
      long_seen <= 1'b0;
    end else begin
      since_en  <= mc_en ? '0 : since_en + 1'b1;
      if (!rst_pin)                   run_cnt <= '0;
      else if (run_cnt != CW'(LIMIT)) run_cnt <= run_cnt + 1'b1;
      long_seen <= core_rst ? 1'b0 : (long_seen || (run_cnt == CW'(LIMIT)));
    end
  end

  assert_mc_period_R1: assert property (@(posedge clk) disable iff (!arst_n)
    mc_en |-> (since_en == PW'(DIV - 1)));

  assert_fetch_a_phase_R2: assert property (@(posedge clk) disable iff (!arst_n)
    fetch_a |-> (since_en == PW'(FA)));

  assert_fetch_b_phase_R2: assert property (@(posedge clk) disable iff (!arst_n)
    fetch_b |-> (since_en == PW'(FB)));

  assert_rst_qualified_R3: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(core_rst) |-> long_seen);

  assert_release_boundary_R5: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(core_rst) |-> $past(mc_en));

  assert_quiet_in_reset_R6: assert property (@(posedge clk) disable iff (!arst_n)
    core_rst |-> (!fetch_a && !fetch_b && !insn_done));

  assert_done_boundary_R9: assert property (@(posedge clk) disable iff (!arst_n)
    insn_done |-> mc_en);

endmodule

bind mcycle_sequencer mcs_checker #(
  .DIV      (DIV),
  .FA       (FA),
  .FB       (FB),
  .RST_MCYC (RST_MCYC)
) u_mcs_checker (
  .clk       (clk),
  .arst_n    (arst_n),
  .rst_pin   (rst_pin),
  .mc_en     (mc_en),
  .fetch_a   (fetch_a),
  .fetch_b   (fetch_b),
  .insn_done (insn_done),
  .core_rst  (core_rst)
);

// File: tb/mcycle_sequencer_bench.sv
module mcycle_sequencer_bench;

  localparam int DIV = 12;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        rst_pin;
  logic [1:0]  insn_class;
  logic        mc_en, fetch_a, fetch_b, insn_done, core_rst;
  logic [15:0] rv_pc, rv_dptr;
  logic [7:0]  rv_acc, rv_b, rv_psw, rv_sp;

  int n_cmp = 0;
  int n_bad = 0;
  int edges = 0;
  int base  = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) edges++;

  mcycle_sequencer u_mcycle_sequencer (
    .clk(clk), .arst_n(arst_n), .rst_pin(rst_pin), .insn_class(insn_class),
    .mc_en(mc_en), .fetch_a(fetch_a), .fetch_b(fetch_b), .insn_done(insn_done),
    .core_rst(core_rst), .rv_pc(rv_pc), .rv_acc(rv_acc), .rv_b(rv_b),
    .rv_psw(rv_psw), .rv_sp(rv_sp), .rv_dptr(rv_dptr)
  );

  task automatic cmp(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", what, act, exp, $time);
    end
  endtask

  function automatic int ph();
    return (edges - base) % DIV;
  endfunction

  task automatic check_rv();
    cmp("R7 rv_pc", rv_pc, 0);   cmp("R7 rv_acc", rv_acc, 0);
    cmp("R7 rv_b", rv_b, 0);     cmp("R7 rv_psw", rv_psw, 0);
    cmp("R7 rv_sp", rv_sp, 7);   cmp("R7 rv_dptr", rv_dptr, 0);
  endtask

  // One instruction of class cls, entered at phase 0 of its first cycle.
  task automatic run_insn(input int cls);
    int ncyc;
    ncyc = (cls == 0) ? 1 : (cls == 3) ? 4 : 2;
    insn_class = 2'(cls);
    for (int c = 0; c < ncyc; c++) begin
      for (int p = 0; p < DIV; p++) begin
        bit sup;
        sup = (cls == 2) && (c == 1);
        cmp("R1 mc_en", mc_en, int'(p == DIV - 1));
        cmp(sup ? "R10 fetch_a" : "R2 fetch_a", fetch_a, int'(p == 1 && !sup));
        cmp(sup ? "R10 fetch_b" : "R2 fetch_b", fetch_b, int'(p == 7 && !sup));
        cmp("R8 R9 insn_done", insn_done, int'(p == DIV - 1 && c == ncyc - 1));
        cmp("R5 core_rst low", core_rst, 0);
        @(negedge clk);
      end
    end
  endtask

  // Long pulse: qualification, quiet window, release on a boundary.
  task automatic reset_pulse(input int len);
    int k;
    bit exp_rst;
    bit released;
    k = 0; exp_rst = 1'b0; released = 1'b0;
    rst_pin = 1'b1;
    while (!released) begin
      @(negedge clk);
      k++;
      if (len >= 24 && k == 26) exp_rst = 1'b1;
      if (exp_rst && k >= len + 3 && ((edges - base - 1) % DIV) == DIV - 1) begin
        exp_rst  = 1'b0;
        released = 1'b1;
      end
      cmp(released ? "R5 core_rst release" : "R3 core_rst", core_rst, int'(exp_rst));
      cmp("R1 mc_en", mc_en, int'(ph() == DIV - 1));
      if (exp_rst) begin
        cmp("R6 fetch_a", fetch_a, 0);
        cmp("R6 fetch_b", fetch_b, 0);
        cmp("R6 insn_done", insn_done, 0);
      end
      if (released) cmp("R5 phase 0 after release", ph(), 0);
      if (k == len) rst_pin = 1'b0;
      if (k > 400) released = 1'b1;
    end
  endtask

  // Short pulse while one-cycle instructions run: nothing may change.
  task automatic short_pulse(input int len);
    insn_class = 2'b00;
    for (int i = 0; i < 6 * DIV; i++) begin
      int p;
      p = i % DIV;
      cmp("R4 core_rst", core_rst, 0);
      cmp("R4 fetch_a", fetch_a, int'(p == 1));
      cmp("R4 fetch_b", fetch_b, int'(p == 7));
      cmp("R4 insn_done", insn_done, int'(p == DIV - 1));
      if (i == 0) rst_pin = 1'b1;
      @(negedge clk);
      if (i + 1 == len) rst_pin = 1'b0;
    end
  endtask

  initial begin
    arst_n = 1'b0; rst_pin = 1'b0; insn_class = 2'b00;
    repeat (3) @(negedge clk);
    cmp("R11 core_rst in arst", core_rst, 1);
    cmp("R11 mc_en in arst", mc_en, 0);
    cmp("R6 fetch_a in arst", fetch_a, 0);
    check_rv();
    arst_n = 1'b1;
    base = edges;
    for (int k = 1; k <= DIV; k++) begin
      @(negedge clk);
      cmp("R11 core_rst after arst", core_rst, int'(k < DIV));
      cmp("R1 mc_en", mc_en, int'(ph() == DIV - 1));
    end
    for (int i = 0; i < 16; i++) begin
      run_insn(i / 4);
      run_insn(i % 4);
    end
    check_rv();
    short_pulse(23);
    short_pulse(10);
    reset_pulse(24);
    run_insn(3);
    reset_pulse(25);
    run_insn(2); run_insn(2);
    reset_pulse(31);
    run_insn(1);
    reset_pulse(40);
    run_insn(0);
    // Reset in the middle of a four-cycle instruction.
    insn_class = 2'b11;
    repeat (18) @(negedge clk);
    reset_pulse(30);
    run_insn(2); run_insn(3); run_insn(0);
    check_rv();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!ended) begin
      ended = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule